// File: doc/BRIEF.md
# At-Speed Scan Delay Test Sequencer

This block wraps a combinational logic block in a chain of multiplexed scan cells. A sequencer drives that chain to apply two-vector delay tests. The first vector (V1) is shifted in serially. The second vector (V2) is then created in one of two ways, and the logic's response to V2 is captured exactly one clock period after V2 is launched.

The two ways of creating V2 are:
- Shift launch: V1 is shifted by one more bit.
- Functional launch: V1 passes through the logic during one functional-mode clock.

The test controller gives a one-cycle start pulse together with a scheme select bit. The controller then streams the scan bits of a fixed number of patterns into the serial input. While each pattern's V1 is shifted in, the previous pattern's captured response comes out on the serial output. After the last pattern a final unload takes place, and the block then signals completion.

The chain contents are presented to the external logic block. The logic's outputs come back on the functional data input. The mode signal comes straight from a flop, so it changes only at clock edges and carries no glitch to the cell muxes.

Top module: `atspeed_scan_seq`

## Requirements
- R1: Each chain cell is a flop fed by a 2:1 mux. When scan_en_o is 1, the next value is: cell 0 takes scan_in_i, cell i takes cell i-1, and scan_out_o equals cell CHAIN_LEN-1. When scan_en_o is 0, every cell takes its bit of func_in_i.
- R2: start_i is accepted only while busy_o is 0. scheme_i is sampled when start is accepted and holds for the whole run. A start pulse or a change of scheme_i during a run has no effect on that run's mode sequence or data.
- R3: Every pattern begins with CHAIN_LEN test-mode cycles that load V1. The first bit driven ends in cell CHAIN_LEN-1.
- R4: With scheme_i = 0 (shift launch), the load is followed by one more test-mode cycle and then exactly one functional-mode cycle. The captured value is f(V2), where V2 = {V1[CHAIN_LEN-2:0], next serial bit}.
- R5: With scheme_i = 1 (functional launch), the load is followed by exactly two functional-mode cycles. The first produces V2 = f(V1), and the second captures f(V2).
- R6: The capture edge is the clock edge directly after the launch edge, and functional mode never lasts more than two consecutive cycles.
- R7: scan_en_o is the output of a flop, and it is 1 in reset and in idle.
- R8: After the capture cycle the block returns to test mode. The next CHAIN_LEN test-mode cycles present the captured bits on scan_out_o, most significant cell first.
- R9: A run applies NUM_PAT patterns. After the last capture there are CHAIN_LEN unload cycles, and then the block goes idle.
- R10: busy_o is 1 from the cycle after start is accepted through the last unload cycle. done_o is a one-cycle pulse in the first idle cycle, when busy_o is already 0.
- R11: After reset, busy_o = 0, done_o = 0, scan_en_o = 1, and all chain cells are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock at rated speed |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle run request |
| scheme_i | input | 1 | 0 = shift launch, 1 = functional launch |
| scan_in_i | input | 1 | Serial scan data into cell 0 |
| func_in_i | input | CHAIN_LEN | Outputs of the wrapped logic block |
| chain_q_o | output | CHAIN_LEN | Chain contents driving the logic block |
| scan_en_o | output | 1 | Mode switch: 1 = test (shift), 0 = functional |
| scan_out_o | output | 1 | Serial data from the last cell |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench follows every cycle of runs under both schemes. It checks the mode switch against the cycle count each scheme requires, which catches:
- a sequencer that adds or drops a launch cycle;
- a sequencer that holds functional mode for a third cycle.

It compares the captured word with f(V2), built arithmetically from the serial bits. This exposes a shift-launch V2 formed from the wrong bit, and a functional launch that captures f(V1) instead of f(f(V1)).

It streams each response out and compares it bit by bit, most significant cell first, which catches a reversed or off-by-one unload.

Runs with a mid-run start pulse and a toggled scheme bit catch a design that restarts, or switches scheme, while busy. The done and busy checks around the final unload catch a pulse that is too early or too long.

// File: rtl/scan_dt_pkg.sv
package scan_dt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_LOAD      = 3'd1,
        ST_LAUNCH_SH = 3'd2,
        ST_LAUNCH_FN = 3'd3,
        ST_CAPTURE   = 3'd4,
        ST_UNLOAD    = 3'd5
    } seq_state_e;

    typedef enum logic {
        LAUNCH_BY_SHIFT = 1'b0,
        LAUNCH_BY_FUNC  = 1'b1
    } launch_e;

    typedef struct packed {
        logic scan_en;
        logic busy;
        logic done;
    } seq_flags_t;

    // test mode (shift) everywhere except the functional launch and capture cycles
    function automatic logic is_test_mode(seq_state_e s);
        return (s != ST_LAUNCH_FN) && (s != ST_CAPTURE);
    endfunction

endpackage

// File: rtl/scan_mux_cell.sv
module scan_mux_cell (
    input  logic clk,
    input  logic rst,
    input  logic sel_scan,
    input  logic scan_d,
    input  logic func_d,
    output logic q
);
    logic d_mux;

    always_comb d_mux = sel_scan ? scan_d : func_d;

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= d_mux;
    end
endmodule

// File: rtl/scan_chain.sv
module scan_chain #(
    parameter int CHAIN_LEN = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scan_en,
    input  logic                 scan_in,
    input  logic [CHAIN_LEN-1:0] func_in,
    output logic [CHAIN_LEN-1:0] chain_q,
    output logic                 scan_out
);
    logic [CHAIN_LEN-1:0] serial_src;

    for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
        if (i == 0) begin : g_head
            assign serial_src[i] = scan_in;
        end else begin : g_body
            assign serial_src[i] = chain_q[i-1];
        end
        scan_mux_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .sel_scan(scan_en),
            .scan_d  (serial_src[i]),
            .func_d  (func_in[i]),
            .q       (chain_q[i])
        );
    end

    assign scan_out = chain_q[CHAIN_LEN-1];

    // R1
    shift_head_chk: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> chain_q[0] == $past(scan_in));
    // R1
    shift_body_chk: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> chain_q[CHAIN_LEN-1:1] == $past(chain_q[CHAIN_LEN-2:0]));
    // R1
    func_load_chk: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> chain_q == $past(func_in));
endmodule

// File: rtl/delay_seq_ctrl.sv
module delay_seq_ctrl
    import scan_dt_pkg::*;
#(
    parameter int CHAIN_LEN = 8,
    parameter int NUM_PAT   = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       scheme,
    output seq_flags_t flags
);
    localparam int CW = $clog2(CHAIN_LEN + 1);
    localparam int PW = $clog2(NUM_PAT + 1);
    localparam logic [CW-1:0] LAST_BIT = CW'(CHAIN_LEN - 1);
    localparam logic [PW-1:0] LAST_PAT = PW'(NUM_PAT - 1);

    seq_state_e    state_q, state_d;
    logic [CW-1:0] bit_q, bit_d;
    logic [PW-1:0] pat_q, pat_d;
    launch_e       scheme_q, scheme_d;
    logic          scan_en_q, done_q, done_d;

    always_comb begin
        state_d  = state_q;
        bit_d    = bit_q;
        pat_d    = pat_q;
        scheme_d = scheme_q;
        done_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d  = ST_LOAD;
                    bit_d    = '0;
                    pat_d    = '0;
                    scheme_d = launch_e'(scheme);
                end
            end
            ST_LOAD: begin
                if (bit_q == LAST_BIT) begin
                    bit_d   = '0;
                    state_d = (scheme_q == LAUNCH_BY_FUNC) ? ST_LAUNCH_FN : ST_LAUNCH_SH;
                end else begin
                    bit_d = bit_q + 1'b1;
                end
            end
            ST_LAUNCH_SH: state_d = ST_CAPTURE;
            ST_LAUNCH_FN: state_d = ST_CAPTURE;
            ST_CAPTURE: begin
                bit_d = '0;
                if (pat_q == LAST_PAT) begin
                    state_d = ST_UNLOAD;
                end else begin
                    pat_d   = pat_q + 1'b1;
                    state_d = ST_LOAD;
                end
            end
            ST_UNLOAD: begin
                if (bit_q == LAST_BIT) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end else begin
                    bit_d = bit_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            bit_q     <= '0;
            pat_q     <= '0;
            scheme_q  <= LAUNCH_BY_SHIFT;
            scan_en_q <= 1'b1;
            done_q    <= 1'b0;
        end else begin
            state_q   <= state_d;
            bit_q     <= bit_d;
            pat_q     <= pat_d;
            scheme_q  <= scheme_d;
            scan_en_q <= is_test_mode(state_d);
            done_q    <= done_d;
        end
    end

    always_comb begin
        flags.scan_en = scan_en_q;
        flags.busy    = (state_q != ST_IDLE);
        flags.done    = done_q;
    end

    // R2
    scheme_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flags.busy && $past(flags.busy)) |-> $stable(scheme_q));
    // R6
    launch_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LAUNCH_SH || state_q == ST_LAUNCH_FN) |=> (state_q == ST_CAPTURE && !scan_en_q));
    // R6
    func_window_chk: assert property (@(posedge clk) disable iff (rst)
        (!scan_en_q && !$past(scan_en_q)) |=> scan_en_q);
    // R8
    back_to_test_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CAPTURE) |=> scan_en_q);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !flags.busy);
    // R7
    idle_mode_chk: assert property (@(posedge clk) disable iff (rst)
        !flags.busy |-> scan_en_q);
endmodule

// File: rtl/atspeed_scan_seq.sv
module atspeed_scan_seq
    import scan_dt_pkg::*;
#(
    parameter int CHAIN_LEN = 8,
    parameter int NUM_PAT   = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic                 scheme_i,
    input  logic                 scan_in_i,
    input  logic [CHAIN_LEN-1:0] func_in_i,
    output logic [CHAIN_LEN-1:0] chain_q_o,
    output logic                 scan_en_o,
    output logic                 scan_out_o,
    output logic                 busy_o,
    output logic                 done_o
);
    seq_flags_t flags;

    delay_seq_ctrl #(
        .CHAIN_LEN(CHAIN_LEN),
        .NUM_PAT  (NUM_PAT)
    ) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start_i),
        .scheme(scheme_i),
        .flags (flags)
    );

    scan_chain #(
        .CHAIN_LEN(CHAIN_LEN)
    ) u_chain (
        .clk     (clk),
        .rst     (rst),
        .scan_en (flags.scan_en),
        .scan_in (scan_in_i),
        .func_in (func_in_i),
        .chain_q (chain_q_o),
        .scan_out(scan_out_o)
    );

    assign scan_en_o = flags.scan_en;
    assign busy_o    = flags.busy;
    assign done_o    = flags.done;
endmodule

// File: tb/atspeed_scan_seq_tb.sv
module atspeed_scan_seq_tb_top;
    localparam int L  = 8;
    localparam int NP = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic         scheme_i = 1'b0;
    logic         scan_in_i = 1'b0;
    logic [L-1:0] func_in_i;
    logic [L-1:0] chain_q_o;
    logic         scan_en_o, scan_out_o, busy_o, done_o;

    int n_checks = 0;
    int n_errors = 0;
    logic [15:0] lfsr = 16'hACE1;

    function automatic logic [L-1:0] logic_f(input logic [L-1:0] x);
        return {x[L-2:0], x[L-1]} ^ (x >> 2) ^ L'(8'h5A);
    endfunction

    assign func_in_i = logic_f(chain_q_o);

    always #10 clk = ~clk;

    atspeed_scan_seq #(.CHAIN_LEN(L), .NUM_PAT(NP)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .scheme_i(scheme_i),
        .scan_in_i(scan_in_i), .func_in_i(func_in_i), .chain_q_o(chain_q_o),
        .scan_en_o(scan_en_o), .scan_out_o(scan_out_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic next_bit();
        logic b;
        b = lfsr[0];
        lfsr = {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
        return b;
    endfunction

    // one run: NP patterns, every cycle checked against the expected schedule
    task automatic run_session(input logic scheme, input logic disturb);
        logic [L-1:0] v1, v2, cap;
        logic b;
        logic have_prev = 1'b0;
        string rq;
        cap = '0;
        rq = disturb ? "R2" : (scheme ? "R5" : "R4");
        @(negedge clk);
        chk("R2", "busy before start", 32'(busy_o), 32'd0);
        start_i = 1'b1;
        scheme_i = scheme;
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            v1 = '0;
            for (int k = 0; k < L; k++) begin
                start_i = 1'b0;
                if (disturb && p == 1 && k == 2) begin
                    start_i  = 1'b1;
                    scheme_i = ~scheme;
                end
                chk("R3", "load mode", 32'(scan_en_o), 32'd1);
                chk("R10", "busy during load", 32'(busy_o), 32'd1);
                if (have_prev) chk("R8", "unload bit", 32'(scan_out_o), 32'(cap[L-1-k]));
                b = next_bit();
                scan_in_i = b;
                v1 = {v1[L-2:0], b};
                @(negedge clk);
            end
            start_i = 1'b0;
            chk("R3", "V1 loaded", 32'(chain_q_o), 32'(v1));
            if (scheme == 1'b0) begin
                chk(rq, "launch shift mode", 32'(scan_en_o), 32'd1);
                b = next_bit();
                scan_in_i = b;
                v2 = {v1[L-2:0], b};
                @(negedge clk);
                chk(rq, "capture mode", 32'(scan_en_o), 32'd0);
                chk("R1", "V2 by shift", 32'(chain_q_o), 32'(v2));
            end else begin
                chk(rq, "launch func mode", 32'(scan_en_o), 32'd0);
                v2 = logic_f(v1);
                @(negedge clk);
                chk("R6", "capture mode", 32'(scan_en_o), 32'd0);
                chk("R5", "V2 by function", 32'(chain_q_o), 32'(v2));
            end
            @(negedge clk);
            cap = logic_f(v2);
            chk(rq, "captured response", 32'(chain_q_o), 32'(cap));
            chk("R8", "test mode after capture", 32'(scan_en_o), 32'd1);
            have_prev = 1'b1;
        end
        for (int k = 0; k < L; k++) begin
            chk("R9", "final unload bit", 32'(scan_out_o), 32'(cap[L-1-k]));
            chk("R9", "final unload mode", 32'(scan_en_o), 32'd1);
            chk("R10", "busy in unload", 32'(busy_o), 32'd1);
            chk("R10", "no early done", 32'(done_o), 32'd0);
            scan_in_i = 1'b0;
            @(negedge clk);
        end
        chk("R10", "done pulse", 32'(done_o), 32'd1);
        chk("R10", "busy low at done", 32'(busy_o), 32'd0);
        chk("R7", "idle mode", 32'(scan_en_o), 32'd1);
        @(negedge clk);
        chk("R10", "done one cycle", 32'(done_o), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11
        chk("R11", "busy after reset", 32'(busy_o), 32'd0);
        chk("R11", "done after reset", 32'(done_o), 32'd0);
        chk("R11", "mode after reset", 32'(scan_en_o), 32'd1);
        chk("R11", "chain after reset", 32'(chain_q_o), 32'd0);
        for (int s = 0; s < 8; s++) begin
            run_session(s[0], s[1]);
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule